// File: doc/BRIEF.md
# Transmit Halt Sequencer

This block decides when an Ethernet transmitter, fed from a transmit FIFO, has come to an orderly stop. Software raises a stop request. The sequencer lets the frame already on the wire finish. If the start of a following frame is already queued, that frame is allowed to finish as well. Then the sequencer reports completion. While it works, it holds off any further frame starts through a hold signal that the transmit path obeys.

A bus error pulse from the DMA engine switches the sequencer to a stricter rule. Every complete frame still held in the FIFO is sent, and each status write-back is counted. Completion is reported only after the last of those writes. A partial frame that cannot be completed is cut off: the sequencer pulses an abort request, and the transmit path then ends that frame as an underrun with a corrupted CRC. When nothing complete is queued, completion is reported at once. The block also produces the per-frame transmit interrupt, which is raised only after the status write-back of that frame.

Top module: `tx_halt_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `stop_done`, `abort_req` and `frame_irq` are 0. With `stop_req` and `bus_err` low, `hold_start` is also 0.
- R2: A stop request taken with `tx_active`=1 and `next_queued`=0 raises `stop_done` in the cycle after the `frame_done` that ends the current frame, and not before.
- R3: A stop request taken with `tx_active`=1 and `next_queued`=1 ignores the first `frame_done`. It raises `stop_done` in the cycle after the second `frame_done`.
- R4: A stop request taken with `tx_active`=0 and `next_queued`=0 raises `stop_done` in the following cycle.
- R5: A `bus_err` pulse with `full_frames`=N>0 raises `stop_done` in the cycle after the Nth `status_wr` pulse. `frame_done` has no effect on this count.
- R6: A `bus_err` pulse with `full_frames`=0 and `part_queued`=0 raises `stop_done` in the following cycle and leaves `abort_req` low. A `bus_err` that arrives once stopped has no effect.
- R7: If `part_queued`=1 at the moment a bus-error stop would complete, `abort_req` and `stop_done` pulse together in the following cycle. This covers both the immediate case and the case after draining complete frames.
- R8: A `bus_err` during a graceful drain discards the graceful count and applies the R5–R7 rules from that cycle on.
- R9: `hold_start` is high in every cycle the sequencer is not idle. With `HOLD_EARLY`=1 it is also high in the idle cycle in which `stop_req` or `bus_err` is sampled. After stopping, it stays high until `stop_req` is low.
- R10: `stop_done` and `abort_req` are single-cycle pulses.
- R11: `frame_irq` pulses in the cycle after each `status_wr` pulse and never because of `frame_done` alone.
- R12: A `frame_done` (graceful) or `status_wr` (bus error) that falls in the same cycle as the request or error counts as already done when the outstanding-frame count is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Graceful stop request level from software |
| bus_err | input | 1 | One-cycle bus error pulse from the DMA engine |
| tx_active | input | 1 | A frame is being transmitted |
| next_queued | input | 1 | The start of a following frame is in the FIFO |
| full_frames | input | CNT_W | Complete frames in the FIFO whose status is not yet written |
| part_queued | input | 1 | An incomplete frame is in the FIFO |
| frame_done | input | 1 | One-cycle pulse: a frame finished on the wire |
| status_wr | input | 1 | One-cycle pulse: a frame's last descriptor status was written |
| hold_start | output | 1 | Blocks the start of new frames |
| stop_done | output | 1 | One-cycle stop-complete pulse to the event register |
| abort_req | output | 1 | One-cycle underrun/bad-CRC abort request to the transmit path |
| frame_irq | output | 1 | One-cycle transmit frame interrupt pulse |

## Verification
Several events can fall in the same cycle as a request or error. A stop request can arrive in the same cycle as the `frame_done` of the frame it would wait for. A bus error can coincide with a `status_wr`. A bus error can land in the middle of a graceful drain, including in a cycle that also carries a frame completion. The bench drives each of these coincidences on purpose. A cycle-level reference model in the bench predicts `stop_done`, `abort_req`, `frame_irq` and `hold_start` every cycle, so it catches a completion that comes one frame early or late, and an abort missing from the done cycle.

// File: rtl/txh_pkg.sv
package txh_pkg;
   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_DRAIN_CUR = 3'd1,
      ST_DRAIN_NXT = 3'd2,
      ST_ABORT     = 3'd3,
      ST_STOPPED   = 3'd4
   } txh_state_e;
endpackage

// File: rtl/txh_entry_calc.sv
// Outstanding-frame counts loaded on entry to a drain; a same-cycle
// completion event is treated as already consumed.
module txh_entry_calc #(
   parameter int CNT_W = 4
) (
   input  logic             tx_active,
   input  logic             next_queued,
   input  logic             frame_done,
   input  logic [CNT_W-1:0] full_frames,
   input  logic             status_wr,
   output logic [CNT_W-1:0] g_pend,
   output logic [CNT_W-1:0] b_pend
);
   logic cur_left;
   logic sw_take;

   always_comb begin
      cur_left = tx_active & ~frame_done;
      g_pend   = CNT_W'(cur_left) + CNT_W'(next_queued);
      sw_take  = status_wr & (full_frames != '0);
      b_pend   = full_frames - CNT_W'(sw_take);
   end
endmodule

// File: rtl/txh_hold_gen.sv
module txh_hold_gen #(
   parameter bit HOLD_EARLY = 1'b1
) (
   input  logic busy,
   input  logic stop_req,
   input  logic bus_err,
   output logic hold_start
);
   generate
      if (HOLD_EARLY) begin : g_early
         always_comb hold_start = busy | stop_req | bus_err;
      end else begin : g_late
         always_comb hold_start = busy;
      end
   endgenerate
endmodule

// File: rtl/txh_fsm.sv
module txh_fsm
   import txh_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stop_req,
   input  logic             bus_err,
   input  logic             part_queued,
   input  logic             frame_done,
   input  logic             status_wr,
   input  logic [CNT_W-1:0] g_pend,
   input  logic [CNT_W-1:0] b_pend,
   output logic             busy,
   output logic             stop_done,
   output logic             abort_req,
   output logic             frame_irq
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

   txh_state_e       state, nxt;
   logic [CNT_W-1:0] pend, pend_n;
   logic             berr_mode, mode_n;
   logic             done_n, abort_n;
   logic             draining, ev;

   always_comb begin
      nxt      = state;
      pend_n   = pend;
      mode_n   = berr_mode;
      done_n   = 1'b0;
      abort_n  = 1'b0;
      draining = (state == ST_DRAIN_CUR) || (state == ST_DRAIN_NXT);
      ev       = berr_mode ? status_wr : frame_done;
      if (bus_err && !berr_mode && (state == ST_IDLE || draining)) begin
         mode_n = 1'b1;
         if (b_pend == '0) begin
            done_n = 1'b1;
            if (part_queued) begin
               abort_n = 1'b1;
               nxt     = ST_ABORT;
            end else begin
               nxt = ST_STOPPED;
            end
         end else begin
            pend_n = b_pend;
            nxt    = (b_pend >= TWO) ? ST_DRAIN_NXT : ST_DRAIN_CUR;
         end
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (stop_req) begin
                  if (g_pend == '0) begin
                     done_n = 1'b1;
                     nxt    = ST_STOPPED;
                  end else begin
                     pend_n = g_pend;
                     nxt    = (g_pend >= TWO) ? ST_DRAIN_NXT : ST_DRAIN_CUR;
                  end
               end
            end
            ST_DRAIN_CUR, ST_DRAIN_NXT: begin
               if (ev) begin
                  if (pend <= ONE) begin
                     done_n = 1'b1;
                     if (berr_mode && part_queued) begin
                        abort_n = 1'b1;
                        nxt     = ST_ABORT;
                     end else begin
                        nxt = ST_STOPPED;
                     end
                  end else begin
                     pend_n = pend - ONE;
                     nxt    = (pend > TWO) ? ST_DRAIN_NXT : ST_DRAIN_CUR;
                  end
               end
            end
            ST_ABORT:   nxt = ST_STOPPED;
            ST_STOPPED: begin
               if (!stop_req) begin
                  nxt    = ST_IDLE;
                  mode_n = 1'b0;
               end
            end
            default:    nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         pend      <= '0;
         berr_mode <= 1'b0;
         stop_done <= 1'b0;
         abort_req <= 1'b0;
         frame_irq <= 1'b0;
      end else begin
         state     <= nxt;
         pend      <= pend_n;
         berr_mode <= mode_n;
         stop_done <= done_n;
         abort_req <= abort_n;
         frame_irq <= status_wr;
      end
   end

   always_comb busy = (state != ST_IDLE);
endmodule

// File: rtl/tx_halt_seq.sv
module tx_halt_seq #(
   parameter int CNT_W      = 4,
   parameter bit HOLD_EARLY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stop_req,
   input  logic             bus_err,
   input  logic             tx_active,
   input  logic             next_queued,
   input  logic [CNT_W-1:0] full_frames,
   input  logic             part_queued,
   input  logic             frame_done,
   input  logic             status_wr,
   output logic             hold_start,
   output logic             stop_done,
   output logic             abort_req,
   output logic             frame_irq
);
   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt_w
         $error("tx_halt_seq: CNT_W must lie in 2..16");
      end
   endgenerate

   logic [CNT_W-1:0] g_pend, b_pend;
   logic             busy;

   txh_entry_calc #(.CNT_W(CNT_W)) u_entry (
      .tx_active  (tx_active),
      .next_queued(next_queued),
      .frame_done (frame_done),
      .full_frames(full_frames),
      .status_wr  (status_wr),
      .g_pend     (g_pend),
      .b_pend     (b_pend)
   );

   txh_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .stop_req   (stop_req),
      .bus_err    (bus_err),
      .part_queued(part_queued),
      .frame_done (frame_done),
      .status_wr  (status_wr),
      .g_pend     (g_pend),
      .b_pend     (b_pend),
      .busy       (busy),
      .stop_done  (stop_done),
      .abort_req  (abort_req),
      .frame_irq  (frame_irq)
   );

   txh_hold_gen #(.HOLD_EARLY(HOLD_EARLY)) u_hold (
      .busy      (busy),
      .stop_req  (stop_req),
      .bus_err   (bus_err),
      .hold_start(hold_start)
   );
endmodule

// File: rtl/tx_halt_seq_chk.sv
module tx_halt_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic status_wr,
   input logic hold_start,
   input logic stop_done,
   input logic abort_req,
   input logic frame_irq
);
   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      stop_done |=> !stop_done);

   a_r10_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
      abort_req |=> !abort_req);

   a_r7_abort_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      abort_req |-> stop_done);

   a_r9_hold_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      stop_done |-> hold_start);

   a_r11_irq_after_status: assert property (@(posedge clk) disable iff (!rst_n)
      frame_irq |-> $past(status_wr));
endmodule

bind tx_halt_seq tx_halt_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .status_wr (status_wr),
   .hold_start(hold_start),
   .stop_done (stop_done),
   .abort_req (abort_req),
   .frame_irq (frame_irq)
);

// File: tb/tx_halt_seq_bench.sv
`timescale 1ns/1ps
module tx_halt_seq_bench;
   localparam int CNT_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stop_req = 0, bus_err = 0, tx_active = 0, next_queued = 0;
   logic [CNT_W-1:0] full_frames = '0;
   logic part_queued = 0, frame_done = 0, status_wr = 0;
   logic hold_start, stop_done, abort_req, frame_irq;

   int n_checks = 0;
   int n_fail = 0;
   string tag = "R1";

   // reference model: phase 0 idle, 1 draining, 2 abort cycle, 3 stopped
   int m_phase = 0;
   int m_rem = 0;
   bit m_berr = 0;
   bit e_done = 0, e_abort = 0, e_irq = 0;

   always #2.5 clk = ~clk;

   tx_halt_seq #(.CNT_W(CNT_W), .HOLD_EARLY(1'b1)) u_tx_halt_seq (
      .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .bus_err(bus_err),
      .tx_active(tx_active), .next_queued(next_queued),
      .full_frames(full_frames), .part_queued(part_queued),
      .frame_done(frame_done), .status_wr(status_wr),
      .hold_start(hold_start), .stop_done(stop_done),
      .abort_req(abort_req), .frame_irq(frame_irq));

   task automatic chk(input string what, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
      end
   endtask

   task automatic finish_stop();
      e_done = 1;
      if (m_berr && part_queued) begin
         e_abort = 1;
         m_phase = 2;
      end else begin
         m_phase = 3;
      end
   endtask

   task automatic model_step();
      e_done = 0; e_abort = 0; e_irq = status_wr;
      if (bus_err && !m_berr && (m_phase == 0 || m_phase == 1)) begin
         m_berr = 1;
         m_rem = int'(full_frames);
         if (status_wr && m_rem > 0) m_rem--;
         if (m_rem == 0) finish_stop(); else m_phase = 1;
      end else if (m_phase == 0) begin
         if (stop_req) begin
            m_rem = ((tx_active && !frame_done) ? 1 : 0) + (next_queued ? 1 : 0);
            if (m_rem == 0) finish_stop(); else m_phase = 1;
         end
      end else if (m_phase == 1) begin
         if (m_berr ? status_wr : frame_done) begin
            if (m_rem <= 1) finish_stop(); else m_rem--;
         end
      end else if (m_phase == 2) begin
         m_phase = 3;
      end else if (!stop_req) begin
         m_phase = 0;
         m_berr = 0;
      end
   endtask

   task automatic cyc(input bit s, input bit be, input bit ta, input bit nq,
                      input int ff, input bit pq, input bit fd, input bit sw);
      stop_req = s; bus_err = be; tx_active = ta; next_queued = nq;
      full_frames = CNT_W'(ff); part_queued = pq; frame_done = fd; status_wr = sw;
      #1;
      chk("hold_start (R9)", hold_start, (m_phase != 0) || s || be);
      model_step();
      @(posedge clk);
      @(negedge clk);
      chk("stop_done", stop_done, e_done);
      chk("abort_req", abort_req, e_abort);
      chk("frame_irq", frame_irq, e_irq);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      // R1: outputs quiet during and just after reset
      tag = "R1";
      repeat (3) @(negedge clk);
      chk("stop_done in reset", stop_done, 1'b0);
      chk("abort_req in reset", abort_req, 1'b0);
      chk("frame_irq in reset", frame_irq, 1'b0);
      chk("hold_start in reset", hold_start, 1'b0);
      rst_n = 1'b1;
      idle(2);

      // R4: request with nothing in flight completes the next cycle
      tag = "R4";
      cyc(1, 0, 0, 0, 0, 0, 0, 0);
      cyc(1, 0, 0, 0, 0, 0, 0, 0);
      cyc(1, 0, 0, 0, 0, 0, 0, 0);
      idle(2);

      // R2: current frame finishes first
      tag = "R2";
      cyc(1, 0, 1, 0, 1, 0, 0, 0);
      cyc(1, 0, 1, 0, 1, 0, 0, 0);
      cyc(1, 0, 1, 0, 1, 0, 0, 0);
      cyc(1, 0, 1, 0, 1, 0, 1, 0);
      cyc(0, 0, 0, 0, 1, 0, 0, 1);
      idle(2);

      // R3: following frame already started in the FIFO
      tag = "R3";
      cyc(1, 0, 1, 1, 2, 0, 0, 0);
      cyc(1, 0, 1, 1, 2, 0, 1, 0);
      cyc(1, 0, 1, 0, 1, 0, 0, 1);
      cyc(1, 0, 1, 0, 1, 0, 1, 0);
      cyc(1, 0, 0, 0, 0, 0, 0, 1);
      cyc(0, 0, 0, 0, 0, 0, 0, 0);
      idle(2);

      // R12: request coincides with the finishing frame
      tag = "R12";
      cyc(1, 0, 1, 0, 1, 0, 1, 0);
      cyc(0, 0, 0, 0, 0, 0, 0, 0);
      idle(2);

      // R5: bus error with three complete frames; frame_done ignored
      tag = "R5";
      cyc(0, 1, 1, 1, 3, 0, 0, 0);
      cyc(0, 0, 1, 1, 3, 0, 1, 0);
      cyc(0, 0, 1, 0, 3, 0, 0, 1);
      cyc(0, 0, 1, 0, 2, 0, 1, 1);
      cyc(0, 0, 1, 0, 1, 0, 0, 0);
      cyc(0, 0, 0, 0, 1, 0, 0, 1);
      idle(3);

      // R6: bus error with an empty FIFO; a later bus error while stopped
      tag = "R6";
      cyc(1, 1, 0, 0, 0, 0, 0, 0);
      cyc(1, 1, 0, 0, 2, 0, 0, 0);
      cyc(1, 0, 0, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 0, 0, 0);
      idle(2);

      // R7: partial frame only, then complete frame followed by partial
      tag = "R7";
      cyc(0, 1, 0, 0, 0, 1, 0, 0);
      idle(3);
      cyc(0, 1, 1, 0, 1, 1, 0, 0);
      cyc(0, 0, 1, 0, 1, 1, 1, 0);
      cyc(0, 0, 0, 0, 1, 1, 0, 1);
      idle(3);

      // R8: bus error in the middle of a graceful two-frame drain
      tag = "R8";
      cyc(1, 0, 1, 1, 2, 0, 0, 0);
      cyc(1, 1, 1, 1, 2, 0, 1, 0);
      cyc(1, 0, 1, 0, 2, 0, 0, 1);
      cyc(1, 0, 1, 0, 1, 0, 1, 0);
      cyc(1, 0, 0, 0, 1, 0, 0, 1);
      cyc(1, 0, 0, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 0, 0, 0);
      idle(2);

      // R12: bus error coincides with the only pending status write
      tag = "R12";
      cyc(0, 1, 0, 0, 1, 0, 0, 1);
      idle(3);

      // R11: interrupt follows status writes only
      tag = "R11";
      cyc(0, 0, 1, 0, 1, 0, 1, 0);
      cyc(0, 0, 0, 0, 1, 0, 0, 1);
      cyc(0, 0, 0, 0, 0, 0, 0, 1);
      idle(2);

      // R10 / R9: long request stays stopped, single pulse, hold kept
      tag = "R10";
      cyc(1, 0, 0, 1, 1, 0, 0, 0);
      cyc(1, 0, 1, 0, 1, 0, 1, 0);
      for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0, 0, 0, 0);
      tag = "R9";
      cyc(0, 0, 0, 0, 0, 0, 0, 0);
      idle(2);

      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule